// File: doc/BRIEF.md
# Deep-Sleep Retention and Wake-Up Controller

This block sits in the always-on domain beside a real-time-clock peripheral. It decides when the chip may drop into deep sleep, switches the core regulator and core clocks off, and keeps the few pieces of state that must survive. It watches for a wake-up and then runs a controlled reset of the core domain once power returns. The RTC counters live in the always-on domain and are outside this block. The block keeps three things: the four RTC interrupt-enable bits, a word of I/O pin state, and the four RTC interrupt flags (time event, alarm, prescaler tick, oscillator fault).

Sleep is entered only when a regulator-off control bit and a sleep command arrive together and the lock is clear. Entry sets the lock. While the lock is set, the retained enables and I/O word stay frozen, even across the wake-up reset. The core's own registers come back at their defaults, so only the lock keeps these values. Software restores its configuration and then pulses the lock-clear strobe. That strobe releases the frozen state and empties the wake-source record. A sleep request made while the lock is still set is dropped.

A wake-up comes from a rising edge on the wake pin or from an RTC flag being raised while its retained enable is set. After a wake-up the regulator turns back on and the core reset stays high until the regulator reports ready. It then stays high for a further `RST_CYC` cycles.

Top module: `lpr_retention_ctrl`

## Requirements
- R1: Sleep is entered on a clock edge only if, in that cycle, the block is awake, `reg_off_i` and `sleep_cmd_i` are both 1 and `lock_o` is 0. Either of the two request inputs on its own leaves the block awake.
- R2: From the edge of entry onward, `reg_en_o`=0, `core_clk_en_o`=0, `core_rst_o`=1 and `lock_o`=1. After reset the block is awake with `reg_en_o`=1, `core_clk_en_o`=1, `core_rst_o`=0 and `lock_o`=0.
- R3: While asleep, `osc_run_o` equals the inverse of `rtc_hold_i`. In every other state it is 1.
- R4: At entry, each flag bit whose enable `ie_i` is 0 in the entry cycle is cleared. This includes a flag raised in that same cycle. Flags whose enable is 1 are kept.
- R5: While `lock_o`=1, `ie_o` and `io_o` hold the values that `ie_i` and `io_i` had in the entry cycle. While unlocked, they follow `ie_i`/`io_i` with one cycle of delay.
- R6: While asleep, the block wakes on a rising edge of `wake_pin_i`, or when `flag_set_i[k]` is raised while retained enable `ie_o[k]` is 1. Flag bit order is 0 time event, 1 alarm, 2 prescaler, 3 oscillator fault. A flag raised with its enable at 0, an oscillator fault included, sets the flag but causes no wake-up.
- R7: On wake-up, `reg_en_o` returns to 1 at the next edge. `core_rst_o` stays 1 until `reg_rdy_i` is seen and then for exactly `RST_CYC` more cycles (default 4). After that the block is awake.
- R8: At wake-up, `wake_src_o` records the causes: bits 3:0 are the enabled flags raised, and bit 4 is the wake-pin edge. It holds this value until the lock is cleared, which sets it to 0.
- R9: `lock_clr_i` clears `lock_o` only while awake. While the core is held in reset it has no effect.
- R10: A sleep request while awake with `lock_o`=1 is ignored. The regulator and clocks stay on.
- R11: `flag_set_i` bits set flags in any state. `flag_ack_i` bits clear flags only while awake and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low always-on reset |
| reg_off_i | input | 1 | Regulator-off control bit |
| sleep_cmd_i | input | 1 | Deep-sleep command |
| rtc_hold_i | input | 1 | RTC hold; 1 stops the 32 kHz oscillator in sleep |
| ie_i | input | 4 | Interrupt enables from core configuration |
| io_i | input | IO_W | Pin state from core configuration |
| flag_set_i | input | 4 | RTC flag raise events |
| flag_ack_i | input | 4 | Software flag clear |
| wake_pin_i | input | 1 | Wake-up pin |
| lock_clr_i | input | 1 | Software lock-clear strobe |
| reg_rdy_i | input | 1 | Core regulator ready |
| reg_en_o | output | 1 | Core regulator enable |
| core_rst_o | output | 1 | Core-domain reset |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_run_o | output | 1 | 32 kHz oscillator enable |
| lock_o | output | 1 | Lock status |
| ie_o | output | 4 | Retained interrupt enables |
| io_o | output | IO_W | Retained pin state |
| flag_o | output | 4 | Pending RTC flags |
| wake_src_o | output | 5 | Recorded wake-up causes |

## Verification
The bound checker tests the following on every cycle:
- Entry qualification and the rejection of requests while locked.
- The masking of disabled flags at entry.
- The freezing of the enable and I/O words under the lock.
- The rule that the core stays asleep unless a wake event is present.
- The length of the reset phase, measured by the checker's own counter.
- The non-empty wake record at wake-up.
- The rule that the lock falls only on an awake lock-clear.

Some behaviours only the bench scenarios can show:
- An oscillator fault with its enable cleared does not wake the block, while one with its enable set does.
- The oscillator follows the hold bit.
- Flag acknowledges are dropped during sleep.
- The wake-source record survives the reset and is then cleared.
- The retained values track the inputs again once unlocked.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESET = 2'd3
  } lpr_state_e;

  // wake causes: enabled flags in the low bits, pin edge on top
  function automatic logic [NSRC:0] wake_hits(input logic            pin_rise,
                                              input logic [NSRC-1:0] set,
                                              input logic [NSRC-1:0] en);
    return {pin_rise, set & en};
  endfunction

  // pending-flag update: acknowledge only when allowed, raise always,
  // then drop disabled bits when sleep is being entered
  function automatic logic [NSRC-1:0] next_flags(input logic [NSRC-1:0] cur,
                                                 input logic [NSRC-1:0] set,
                                                 input logic [NSRC-1:0] ack,
                                                 input logic            ack_ok,
                                                 input logic            entering,
                                                 input logic [NSRC-1:0] keep);
    logic [NSRC-1:0] f;
    f = (cur & ~(ack_ok ? ack : '0)) | set;
    if (entering) f = f & keep;
    return f;
  endfunction

endpackage

// File: rtl/lpr_edge_det.sv
module lpr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/lpr_hold_reg.sv
module lpr_hold_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_o <= '0;
    else if (!freeze_i) q_o <= d_i;
  end
endmodule

// File: rtl/lpr_rst_timer.sv
module lpr_rst_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic last_o
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (!last_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = active_i && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/lpr_retention_ctrl.sv
module lpr_retention_ctrl
  import lpr_pkg::*;
#(
  parameter int IO_W    = 8,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_off_i,
  input  logic              sleep_cmd_i,
  input  logic              rtc_hold_i,
  input  logic [NSRC-1:0]   ie_i,
  input  logic [IO_W-1:0]   io_i,
  input  logic [NSRC-1:0]   flag_set_i,
  input  logic [NSRC-1:0]   flag_ack_i,
  input  logic              wake_pin_i,
  input  logic              lock_clr_i,
  input  logic              reg_rdy_i,
  output logic              reg_en_o,
  output logic              core_rst_o,
  output logic              core_clk_en_o,
  output logic              osc_run_o,
  output logic              lock_o,
  output logic [NSRC-1:0]   ie_o,
  output logic [IO_W-1:0]   io_o,
  output logic [NSRC-1:0]   flag_o,
  output logic [NSRC:0]     wake_src_o
);

  lpr_state_e      state_q, state_d;
  logic            lock_q, lock_d;
  logic [NSRC-1:0] flags_q, flags_d;
  logic [NSRC:0]   src_q, src_d;

  // named internal events (also used by the checker)
  logic            awake;
  logic            entry_ok;
  logic            unlock;
  logic            pin_rise;
  logic [NSRC:0]   hits;
  logic            wake_evt;
  logic            rst_phase;
  logic            rst_last;

  lpr_edge_det u_pin_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (wake_pin_i),
    .rise_o (pin_rise)
  );

  lpr_hold_reg #(.W(NSRC)) u_ie_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (lock_q),
    .d_i      (ie_i),
    .q_o      (ie_o)
  );

  lpr_hold_reg #(.W(IO_W)) u_io_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (lock_q),
    .d_i      (io_i),
    .q_o      (io_o)
  );

  lpr_rst_timer #(.CYC(RST_CYC)) u_rst_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (rst_phase),
    .last_o   (rst_last)
  );

  assign awake     = (state_q == ST_AWAKE);
  assign rst_phase = (state_q == ST_RESET);
  assign entry_ok  = awake && reg_off_i && sleep_cmd_i && !lock_q;
  assign unlock    = awake && lock_clr_i && lock_q;
  assign hits      = wake_hits(pin_rise, flag_set_i, ie_o);
  assign wake_evt  = (state_q == ST_SLEEP) && (|hits);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE: if (entry_ok)  state_d = ST_SLEEP;
      ST_SLEEP: if (wake_evt)  state_d = ST_WAIT;
      ST_WAIT:  if (reg_rdy_i) state_d = ST_RESET;
      ST_RESET: if (rst_last)  state_d = ST_AWAKE;
      default:                 state_d = ST_AWAKE;
    endcase
  end

  always_comb begin
    lock_d = lock_q;
    if (entry_ok)    lock_d = 1'b1;
    else if (unlock) lock_d = 1'b0;
  end

  always_comb begin
    src_d = src_q;
    if (wake_evt)    src_d = hits;
    else if (unlock) src_d = '0;
  end

  assign flags_d = next_flags(flags_q, flag_set_i, flag_ack_i, awake, entry_ok, ie_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      lock_q  <= 1'b0;
      flags_q <= '0;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
      flags_q <= flags_d;
      src_q   <= src_d;
    end
  end

  assign reg_en_o      = (state_q != ST_SLEEP);
  assign core_rst_o    = !awake;
  assign core_clk_en_o = awake;
  assign osc_run_o     = (state_q != ST_SLEEP) || !rtc_hold_i;
  assign lock_o        = lock_q;
  assign flag_o        = flags_q;
  assign wake_src_o    = src_q;

endmodule

// File: rtl/lpr_checker.sv
module lpr_checker #(
  parameter int IO_W    = 8,
  parameter int RST_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_off_i,
  input logic            sleep_cmd_i,
  input logic            lock_clr_i,
  input logic            reg_en_o,
  input logic            core_rst_o,
  input logic            lock_o,
  input logic [3:0]      ie_o,
  input logic [IO_W-1:0] io_o,
  input logic [3:0]      flag_o,
  input logic [4:0]      wake_src_o,
  input logic            wake_evt,
  input logic            rst_phase
);
  int rst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rst_len <= 0;
    else if (rst_phase) rst_len <= rst_len + 1;
    else                rst_len <= 0;
  end

  assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_o && reg_off_i && sleep_cmd_i && !lock_o) |=> (!reg_en_o && lock_o && core_rst_o));

  assert_mask_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en_o) |-> ((flag_o & ~ie_o) == 4'b0000));

  assert_frozen_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && $past(lock_o)) |-> ($stable(ie_o) && $stable(io_o)));

  assert_no_spurious_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en_o && !wake_evt) |=> !reg_en_o);

  assert_wake_powers_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> reg_en_o);

  assert_reset_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (rst_len == RST_CYC));

  assert_src_recorded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en_o) |-> (wake_src_o != 5'b00000));

  assert_unlock_only_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(lock_clr_i) && !$past(core_rst_o) && (wake_src_o == 5'b00000)));

  assert_locked_request_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_o && lock_o && sleep_cmd_i) |=> reg_en_o);

endmodule

bind lpr_retention_ctrl lpr_checker #(.IO_W(IO_W), .RST_CYC(RST_CYC)) i_lpr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_off_i   (reg_off_i),
  .sleep_cmd_i (sleep_cmd_i),
  .lock_clr_i  (lock_clr_i),
  .reg_en_o    (reg_en_o),
  .core_rst_o  (core_rst_o),
  .lock_o      (lock_o),
  .ie_o        (ie_o),
  .io_o        (io_o),
  .flag_o      (flag_o),
  .wake_src_o  (wake_src_o),
  .wake_evt    (wake_evt),
  .rst_phase   (rst_phase)
);

// File: tb/test_lpr_retention_ctrl.sv
`timescale 1ns/100ps
module test_lpr_retention_ctrl;
  localparam int IO_W = 8;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_off_i = 0, sleep_cmd_i = 0, rtc_hold_i = 0;
  logic [3:0] ie_i = '0, flag_set_i = '0, flag_ack_i = '0;
  logic [IO_W-1:0] io_i = '0;
  logic wake_pin_i = 0, lock_clr_i = 0, reg_rdy_i = 0;
  logic reg_en_o, core_rst_o, core_clk_en_o, osc_run_o, lock_o;
  logic [3:0] ie_o, flag_o;
  logic [IO_W-1:0] io_o;
  logic [4:0] wake_src_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpr_retention_ctrl #(.IO_W(IO_W), .RST_CYC(RST_CYC)) i_lpr_retention_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_off_i(reg_off_i), .sleep_cmd_i(sleep_cmd_i),
    .rtc_hold_i(rtc_hold_i), .ie_i(ie_i), .io_i(io_i), .flag_set_i(flag_set_i),
    .flag_ack_i(flag_ack_i), .wake_pin_i(wake_pin_i), .lock_clr_i(lock_clr_i),
    .reg_rdy_i(reg_rdy_i), .reg_en_o(reg_en_o), .core_rst_o(core_rst_o),
    .core_clk_en_o(core_clk_en_o), .osc_run_o(osc_run_o), .lock_o(lock_o),
    .ie_o(ie_o), .io_o(io_o), .flag_o(flag_o), .wake_src_o(wake_src_o)
  );

  // behavioural reference: phase 0 awake, 1 asleep, 2 waiting for power, 3 reset count
  int m_phase = 0;
  int m_rcount = 0;
  bit m_lock = 0;
  bit m_pin_was = 0;
  logic [3:0] m_flags = '0, m_ie = '0;
  logic [4:0] m_src = '0;
  logic [IO_W-1:0] m_io = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_rcount = 0; m_lock = 0; m_pin_was = 0;
      m_flags = '0; m_ie = '0; m_src = '0; m_io = '0;
    end else begin
      bit rise;
      bit was_locked;
      logic [3:0] en_now;
      rise = wake_pin_i && !m_pin_was;
      was_locked = m_lock;
      en_now = m_ie;
      if (m_phase == 0) begin
        for (int k = 0; k < 4; k++) if (flag_ack_i[k]) m_flags[k] = 1'b0;
        m_flags = m_flags | flag_set_i;
        if (reg_off_i && sleep_cmd_i && !m_lock) begin
          for (int k = 0; k < 4; k++) if (!ie_i[k]) m_flags[k] = 1'b0;
          m_lock = 1; m_phase = 1;
        end else if (lock_clr_i && m_lock) begin
          m_lock = 0; m_src = '0;
        end
      end else begin
        m_flags = m_flags | flag_set_i;
        if (m_phase == 1) begin
          if (rise || ((flag_set_i & en_now) != 0)) begin
            m_src = {rise, flag_set_i & en_now};
            m_phase = 2;
          end
        end else if (m_phase == 2) begin
          if (reg_rdy_i) begin m_phase = 3; m_rcount = 0; end
        end else begin
          m_rcount++;
          if (m_rcount == RST_CYC) m_phase = 0;
        end
      end
      if (!was_locked) begin m_ie = ie_i; m_io = io_i; end
      m_pin_was = wake_pin_i;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "reg_en", 32'(reg_en_o), 32'(m_phase != 1));
      chk("R2", "clk_en", 32'(core_clk_en_o), 32'(m_phase == 0));
      chk("R7", "core_rst", 32'(core_rst_o), 32'(m_phase != 0));
      chk("R3", "osc_run", 32'(osc_run_o), 32'((m_phase != 1) || !rtc_hold_i));
      chk("R9", "lock", 32'(lock_o), 32'(m_lock));
      chk("R5", "ie", 32'(ie_o), 32'(m_ie));
      chk("R5", "io", 32'(io_o), 32'(m_io));
      chk("R4", "flags", 32'(flag_o), 32'(m_flags));
      chk("R8", "wake_src", 32'(wake_src_o), 32'(m_src));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cycles++;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wait_awake();
    for (int i = 0; i < 40 && core_rst_o; i++) tick();
  endtask

  task automatic report();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); settle();
    chk("R2", "reset regulator", 32'(reg_en_o), 32'd1);
    chk("R2", "reset lock", 32'(lock_o), 32'd0);

    // R1: each request input alone is not enough
    ie_i = 4'b0001; io_i = 8'hA5;
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0; settle();
    chk("R1", "sleep cmd alone", 32'(reg_en_o), 32'd1);
    reg_off_i = 1; tick(); settle();
    chk("R1", "reg_off alone", 32'(reg_en_o), 32'd1);

    // R11: raise and acknowledge while awake
    flag_set_i = 4'b0101; tick(); flag_set_i = '0; settle();
    chk("R11", "flags raised", 32'(flag_o), 32'h5);
    flag_ack_i = 4'b0001; tick(); flag_ack_i = '0; settle();
    chk("R11", "ack awake", 32'(flag_o), 32'h4);
    flag_set_i = 4'b0001; tick(); flag_set_i = '0;

    // enter with hold set: disabled flag 2 dropped, oscillator stopped
    rtc_hold_i = 1; sleep_cmd_i = 1; tick(); sleep_cmd_i = 0; settle();
    chk("R1", "entered", 32'(reg_en_o), 32'd0);
    chk("R2", "lock set", 32'(lock_o), 32'd1);
    chk("R4", "disabled flag cleared", 32'(flag_o), 32'h1);
    chk("R3", "osc held", 32'(osc_run_o), 32'd0);
    ie_i = 4'b1111; io_i = 8'h3C; tick(); settle();
    chk("R5", "ie frozen", 32'(ie_o), 32'h1);
    chk("R5", "io frozen", 32'(io_o), 32'hA5);
    flag_ack_i = 4'b0001; tick(); flag_ack_i = '0; settle();
    chk("R11", "ack ignored asleep", 32'(flag_o), 32'h1);

    // R6: disabled fault sets flag but does not wake
    flag_set_i = 4'b1000; tick(); flag_set_i = '0; tick(); settle();
    chk("R6", "disabled fault no wake", 32'(reg_en_o), 32'd0);
    chk("R6", "fault flag set", 32'(flag_o), 32'h9);

    // enabled time event wakes
    flag_set_i = 4'b0001; tick(); flag_set_i = '0; settle();
    chk("R6", "time event wakes", 32'(reg_en_o), 32'd1);
    chk("R8", "source time event", 32'(wake_src_o), 32'h01);
    lock_clr_i = 1; tick(); lock_clr_i = 0; settle();
    chk("R9", "clear ignored in reset", 32'(lock_o), 32'd1);
    repeat (3) tick(); settle();
    chk("R7", "held until ready", 32'(core_rst_o), 32'd1);

    reg_rdy_i = 1; tick(); settle();
    n = 0;
    for (int i = 0; i < 20 && core_rst_o; i++) begin n++; tick(); settle(); end
    chk("R7", "reset cycles after ready", 32'(n), 32'(RST_CYC));
    reg_rdy_i = 0;
    ie_i = 4'b0000; io_i = 8'h00; tick(); settle();
    chk("R5", "ie kept over reset", 32'(ie_o), 32'h1);
    chk("R8", "source kept", 32'(wake_src_o), 32'h01);

    // R10: locked request dropped
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0; settle();
    chk("R10", "locked request", 32'(reg_en_o), 32'd1);

    ie_i = 4'b1000; io_i = 8'h5A;
    lock_clr_i = 1; tick(); lock_clr_i = 0; settle();
    chk("R9", "lock cleared", 32'(lock_o), 32'd0);
    chk("R8", "source cleared", 32'(wake_src_o), 32'h00);
    tick(); settle();
    chk("R5", "ie follows unlocked", 32'(ie_o), 32'h8);

    // second round: oscillator running, wake by pin
    flag_ack_i = 4'b1111; tick(); flag_ack_i = '0;
    rtc_hold_i = 0; sleep_cmd_i = 1; tick(); sleep_cmd_i = 0; settle();
    chk("R3", "osc runs unheld", 32'(osc_run_o), 32'd1);
    wake_pin_i = 1; tick(); wake_pin_i = 0; settle();
    chk("R8", "source pin", 32'(wake_src_o), 32'h10);
    reg_rdy_i = 1; wait_awake(); reg_rdy_i = 0;
    lock_clr_i = 1; tick(); lock_clr_i = 0;

    // third round: enabled fault wakes
    rtc_hold_i = 1; sleep_cmd_i = 1; tick(); sleep_cmd_i = 0;
    tick(); tick();
    flag_set_i = 4'b1000; tick(); flag_set_i = '0; settle();
    chk("R6", "enabled fault wakes", 32'(reg_en_o), 32'd1);
    chk("R8", "source fault", 32'(wake_src_o), 32'h08);
    reg_rdy_i = 1; wait_awake(); reg_rdy_i = 0;
    tick(); tick(); settle();
    report();
  end
endmodule